// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This block is the shift and rotate execution stage of an accumulator-based controller. Each operation takes the 32-bit accumulator operand, a shift count, and the three condition flags A1, A0 and OV. It returns the new accumulator value and the new flags.

The count comes from an 8-bit immediate when the instruction carries one. Otherwise it comes from the low byte of a second accumulator. Word-sized operations act on bits 15..0 only and pass the upper half through unchanged. Flag A1 works as the carry: it takes the last bit pushed out, and it is the bit that enters the vacated end in the two single-step rotates through the flag.

A request is presented with a one-cycle valid strobe. The result appears on registered outputs one clock later, marked by a done strobe, and it holds until the next request.

Top module: `sr_shift_unit`

## Requirements
- R1: `done` is high in exactly the cycle after each cycle with `in_valid` high. `acc_out` and `stat_out` change only on those edges. A synchronous active-low reset sets `acc_out`, `stat_out` and `done` to zero.
- R2: When `use_imm` is 1, the count is `imm_cnt`. When `use_imm` is 0, the count is `acc_b_lo`. Counts range over 0..255.
- R3: Word operations (op 0, 2, 3) give `acc_out[31:16]` equal to `acc_a[31:16]`.
- R4: Logical shifts fill the vacated positions with zeros. For word shifts left (op 2) and right (op 3), and double-word shifts left (op 4) and right (op 5), a count of n ≥ 1 sets A1 to the last bit shifted out of the field. Any count at or above the field width (16 or 32) gives the full-width result: the field is cleared, and A1 is field bit 0 for a left shift or the top field bit for a right shift.
- R5: Arithmetic right shifts on the word (op 0) and double word (op 1) fill with the field's sign bit, which is bit 15 or bit 31. A1 is the last bit shifted out. A count at or above the width leaves every field bit equal to the sign, and A1 equal to the sign.
- R6: A 32-bit rotate left (op 6) or right (op 7) by count c moves the value by c mod 32 positions. For c ≠ 0, A1 equals `acc_out[0]` after a left rotate and `acc_out[31]` after a right rotate. This holds even when c is a multiple of 32, in which case the value is returned unchanged.
- R7: Rotate left through A1 (op 8) gives `{acc_a[30:0], A1}` and a new A1 of `acc_a[31]`. Rotate right through A1 (op 9) gives `{A1, acc_a[31:1]}` and a new A1 of `acc_a[0]`. Neither uses the count.
- R8: A counted operation (op 0..7) with a count of zero returns `acc_a` unchanged and `stat_in` unchanged.
- R9: Any operation of op 0..9 that is not covered by R8 clears A0 and OV.
- R10: Op codes 10..15 are not operations. They return `acc_a` and `stat_in` unchanged and still raise `done`. In all flag vectors, bit 2 is A1, bit 1 is A0 and bit 0 is OV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| op | input | 4 | Operation code (see R4 to R10) |
| use_imm | input | 1 | 1: take the count from `imm_cnt`; 0: take it from `acc_b_lo` |
| imm_cnt | input | 8 | Immediate count |
| acc_b_lo | input | 8 | Low byte of the second accumulator |
| acc_a | input | 32 | Accumulator operand |
| stat_in | input | 3 | Current flags {A1, A0, OV} |
| done | output | 1 | Result strobe, one cycle after `in_valid` |
| acc_out | output | 32 | Registered result |
| stat_out | output | 3 | Registered flags {A1, A0, OV} |

## Verification
Every result is due on the first rising edge after the cycle in which `in_valid` is sampled high, so all three outputs are settled one full cycle after the request. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a period after the edge that loads them. It does this for both the value checks and the `done` check. For held values, it keeps the unit idle with different inputs for one more cycle and reads the outputs again at the following falling edge.

// File: rtl/sr_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes: op codes are 4 bits; values 10..15 are not operations.
package sr_pkg;

    typedef enum logic [3:0] {
        OP_SRA_W = 4'd0,
        OP_SRA_D = 4'd1,
        OP_SLL_W = 4'd2,
        OP_SRL_W = 4'd3,
        OP_SLL_D = 4'd4,
        OP_SRL_D = 4'd5,
        OP_ROL_D = 4'd6,
        OP_ROR_D = 4'd7,
        OP_ROL_C = 4'd8,
        OP_ROR_C = 4'd9
    } sr_op_e;

    typedef enum logic [1:0] {
        SK_LEFT = 2'd0,
        SK_RLOG = 2'd1,
        SK_RARI = 2'd2
    } shift_kind_e;

    // Flag vector positions
    localparam int FLAG_A1 = 2;
    localparam int FLAG_A0 = 1;
    localparam int FLAG_OV = 0;

endpackage

// File: rtl/sr_count_sel.sv
// Picks the shift count: the immediate or the second accumulator's low byte.
// Assumes: both sources are CNT_W bits wide.
module sr_count_sel #(
    parameter int CNT_W = 8
) (
    input  logic             use_imm,
    input  logic [CNT_W-1:0] imm_cnt,
    input  logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);

    // Choose the count source and flag a zero count
    always_comb begin
        cnt      = use_imm ? imm_cnt : acc_cnt;
        cnt_zero = (cnt == '0);
    end

endmodule

// File: rtl/sr_field_shift.sv
// Shifts a W-bit field left, logical right or arithmetic right and returns
// the last bit pushed out. Counts at or above W are clamped to W.
// Assumes: a zero count is handled by the caller (last_out is then 0).
module sr_field_shift
    import sr_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 8
) (
    input  logic [W-1:0]     val,
    input  logic [CNT_W-1:0] cnt,
    input  shift_kind_e      kind,
    output logic [W-1:0]     res,
    output logic             last_out
);

    localparam int NW = $clog2(W + 1);

    logic [NW-1:0]     n;
    logic signed [W:0] ext_r;

    // Clamp the count to the field width
    always_comb begin
        n = (cnt >= CNT_W'(W)) ? NW'(W) : NW'(cnt);
    end

    // Shift one extra guard bit along to catch the last bit out
    always_comb begin
        ext_r = $signed({val, 1'b0});
        unique case (kind)
            SK_LEFT: {last_out, res} = {1'b0, val} << n;
            SK_RARI: {res, last_out} = ext_r >>> n;
            default: {res, last_out} = {val, 1'b0} >> n;
        endcase
    end

endmodule

// File: rtl/sr_rotate.sv
// Rotates a W-bit value left or right by a count taken modulo W.
// Assumes: W is a power of two.
module sr_rotate #(
    parameter int W = 32,
    localparam int RW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [RW-1:0] r,
    input  logic          left,
    output logic [W-1:0]  res
);

    logic [RW-1:0] rc;

    // The complement amount W-r; when r is 0 both halves equal val
    always_comb begin
        rc  = -r;
        res = left ? ((val << r) | (val >> rc)) : ((val >> r) | (val << rc));
    end

endmodule

// File: rtl/sr_shift_unit.sv
// Top of the shift/rotate unit. Decodes the op, runs the word shifter, the
// double-word shifter and the rotator in parallel, selects the result and
// registers it with a one-cycle latency.
// Assumes: one request per in_valid pulse; stat vectors are {A1, A0, OV}.
module sr_shift_unit
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int ROT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              use_imm,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [CNT_W-1:0]  acc_b_lo,
    input  logic [DATA_W-1:0] acc_a,
    input  logic [2:0]        stat_in,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [2:0]        stat_out
);

    sr_op_e             op_q;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_zero;
    shift_kind_e        w_kind, d_kind;
    logic [HALF_W-1:0]  w_res;
    logic               w_last;
    logic [DATA_W-1:0]  d_res;
    logic               d_last;
    logic [DATA_W-1:0]  r_res;
    logic               rot_left;
    logic [DATA_W-1:0]  nxt_acc;
    logic [2:0]         nxt_stat;
    logic               nxt_a1;
    logic               is_counted;
    logic               is_known;

    sr_count_sel #(.CNT_W(CNT_W)) u_cnt (
        .use_imm  (use_imm),
        .imm_cnt  (imm_cnt),
        .acc_cnt  (acc_b_lo),
        .cnt      (cnt),
        .cnt_zero (cnt_zero)
    );

    // Decode the op into shifter kinds and rotate direction
    always_comb begin
        op_q     = sr_op_e'(op);
        w_kind   = SK_LEFT;
        d_kind   = SK_LEFT;
        rot_left = (op_q == OP_ROL_D);
        unique case (op_q)
            OP_SRA_W: w_kind = SK_RARI;
            OP_SRL_W: w_kind = SK_RLOG;
            OP_SRA_D: d_kind = SK_RARI;
            OP_SRL_D: d_kind = SK_RLOG;
            default:  ;
        endcase
        is_counted = (op <= 4'd7);
        is_known   = (op <= 4'd9);
    end

    sr_field_shift #(.W(HALF_W), .CNT_W(CNT_W)) u_word (
        .val      (acc_a[HALF_W-1:0]),
        .cnt      (cnt),
        .kind     (w_kind),
        .res      (w_res),
        .last_out (w_last)
    );

    sr_field_shift #(.W(DATA_W), .CNT_W(CNT_W)) u_dword (
        .val      (acc_a),
        .cnt      (cnt),
        .kind     (d_kind),
        .res      (d_res),
        .last_out (d_last)
    );

    sr_rotate #(.W(DATA_W)) u_rot (
        .val  (acc_a),
        .r    (cnt[ROT_W-1:0]),
        .left (rot_left),
        .res  (r_res)
    );

    // Select the result and the new carry flag
    always_comb begin
        nxt_acc = acc_a;
        nxt_a1  = stat_in[FLAG_A1];
        unique case (op_q)
            OP_SRA_W, OP_SLL_W, OP_SRL_W: begin
                nxt_acc = {acc_a[DATA_W-1:HALF_W], w_res};
                nxt_a1  = w_last;
            end
            OP_SRA_D, OP_SLL_D, OP_SRL_D: begin
                nxt_acc = d_res;
                nxt_a1  = d_last;
            end
            OP_ROL_D: begin
                nxt_acc = r_res;
                nxt_a1  = r_res[0];
            end
            OP_ROR_D: begin
                nxt_acc = r_res;
                nxt_a1  = r_res[DATA_W-1];
            end
            OP_ROL_C: begin
                nxt_acc = {acc_a[DATA_W-2:0], stat_in[FLAG_A1]};
                nxt_a1  = acc_a[DATA_W-1];
            end
            OP_ROR_C: begin
                nxt_acc = {stat_in[FLAG_A1], acc_a[DATA_W-1:1]};
                nxt_a1  = acc_a[0];
            end
            default: ;
        endcase
        if (!is_known || (is_counted && cnt_zero)) begin
            nxt_acc  = acc_a;
            nxt_stat = stat_in;
        end else begin
            nxt_stat = {nxt_a1, 2'b00};
        end
    end

    // Output registers with one-cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            acc_out  <= '0;
            stat_out <= '0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                acc_out  <= nxt_acc;
                stat_out <= nxt_stat;
            end
        end
    end

endmodule

// File: rtl/sr_shift_unit_chk.sv
// Checker for sr_shift_unit, attached by bind. Relates requests to the
// registered results one cycle later.
module sr_shift_unit_chk
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic              use_imm,
    input logic [CNT_W-1:0]  imm_cnt,
    input logic [CNT_W-1:0]  acc_b_lo,
    input logic [DATA_W-1:0] acc_a,
    input logic [2:0]        stat_in,
    input logic              done,
    input logic [DATA_W-1:0] acc_out,
    input logic [2:0]        stat_out
);

    logic [CNT_W-1:0] c_cnt;
    logic             c_word;
    // Count seen by the request, for property predicates
    always_comb begin
        c_cnt  = use_imm ? imm_cnt : acc_b_lo;
        c_word = (op == OP_SRA_W) || (op == OP_SLL_W) || (op == OP_SRL_W);
    end

    a_r1_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_out) && $stable(stat_out)));
    a_r3_high_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_word) |=> acc_out[DATA_W-1:DATA_W/2] == $past(acc_a[DATA_W-1:DATA_W/2]));
    a_r8_zero_count_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd7 && c_cnt == '0) |=> (acc_out == $past(acc_a) && stat_out == $past(stat_in)));
    a_r9_clear_a0_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd9 && !(op <= 4'd7 && c_cnt == '0)) |=> stat_out[1:0] == 2'b00);
    a_r7_rotc_left: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROL_C) |=> (acc_out[0] == $past(stat_in[2]) && stat_out[2] == $past(acc_a[DATA_W-1])));
    a_r7_rotc_right: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ROR_C) |=> (acc_out[DATA_W-1] == $past(stat_in[2]) && stat_out[2] == $past(acc_a[0])));
    a_r10_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd9) |=> (acc_out == $past(acc_a) && stat_out == $past(stat_in)));

endmodule

bind sr_shift_unit sr_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_sr_shift_unit.sv
`timescale 1ns/1ps
module test_sr_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_cnt = '0;
    logic [7:0]  acc_b_lo = '0;
    logic [31:0] acc_a = '0;
    logic [2:0]  stat_in = '0;
    logic        done;
    logic [31:0] acc_out;
    logic [2:0]  stat_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sr_shift_unit i_sr_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .use_imm(use_imm), .imm_cnt(imm_cnt), .acc_b_lo(acc_b_lo),
        .acc_a(acc_a), .stat_in(stat_in), .done(done),
        .acc_out(acc_out), .stat_out(stat_out)
    );

    // Reference model: bit-at-a-time stepping; returns {acc, A1, A0, OV}
    function automatic logic [34:0] model(input logic [3:0] o, input logic [31:0] a,
                                          input logic [7:0] c, input logic [2:0] st);
        logic [31:0] v;
        logic last;
        int w;
        int steps;
        if (o > 4'd9) return {a, st};
        if (o <= 4'd7 && c == 8'd0) return {a, st};
        last = st[2];
        if (o == 4'd8) return {a[30:0], st[2], a[31], 2'b00};
        if (o == 4'd9) return {st[2], a[31:1], a[0], 2'b00};
        if (o == 4'd6 || o == 4'd7) begin
            v = a;
            for (int k = 0; k < int'(c); k++) begin
                if (o == 4'd6) begin last = v[31]; v = {v[30:0], last}; end
                else begin last = v[0]; v = {last, v[31:1]}; end
            end
            return {v, last, 2'b00};
        end
        w = (o == 4'd0 || o == 4'd2 || o == 4'd3) ? 16 : 32;
        v = (w == 16) ? {16'h0, a[15:0]} : a;
        steps = (int'(c) > w) ? w : int'(c);
        for (int k = 0; k < steps; k++) begin
            if (o == 4'd2 || o == 4'd4) begin
                last = v[w-1];
                v = v << 1;
                if (w == 16) v[16] = 1'b0;
            end else if (o == 4'd3 || o == 4'd5) begin
                last = v[0];
                v = v >> 1;
            end else begin
                logic s;
                s = v[w-1];
                last = v[0];
                v = v >> 1;
                v[w-1] = s;
            end
        end
        if (w == 16) return {a[31:16], v[15:0], last, 2'b00};
        return {v, last, 2'b00};
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [7:0] c);
        if (o > 4'd9) return "R10";
        if (o <= 4'd7 && c == 8'd0) return "R8";
        if (o == 4'd0 || o == 4'd1) return "R5";
        if (o <= 4'd5) return "R4";
        if (o <= 4'd7) return "R6";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got acc=%h st=%b expected acc=%h st=%b",
                     tag, got[34:3], got[2:0], exp[34:3], exp[2:0]);
        end
    endtask

    // Drive one request at the falling edge, read the result one cycle later
    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic ui,
                       input logic [7:0] imm, input logic [7:0] bl, input logic [2:0] st);
        logic [7:0] c;
        logic [34:0] exp;
        c = ui ? imm : bl;
        @(negedge clk);
        op = o; acc_a = a; use_imm = ui; imm_cnt = imm; acc_b_lo = bl; stat_in = st;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = model(o, a, c, st);
        check(tag_of(o, c), {acc_out, stat_out}, exp);
        check("R1 done", {34'h0, done}, 35'h1);
        if (o == 4'd0 || o == 4'd2 || o == 4'd3)
            check("R3", {19'h0, acc_out[31:16]}, {19'h0, a[31:16]});
        if (o <= 4'd9 && !(o <= 4'd7 && c == 8'd0))
            check("R9", {33'h0, stat_out[1:0]}, 35'h0);
    endtask

    function automatic logic [7:0] pick_cnt();
        case ($urandom % 10)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'd15;
            3: return 8'd16;
            4: return 8'd17;
            5: return 8'd31;
            6: return 8'd32;
            7: return 8'd64;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        logic [34:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset", {acc_out, stat_out}, 35'h0);
        check("R1 reset done", {34'h0, done}, 35'h0);
        rst_n = 1'b1;

        // R5 word arithmetic shift by 16 of a negative half
        run(4'd0, 32'h1234_8000, 1'b1, 8'd16, 8'd0, 3'b000);
        check("R5 fill", {acc_out, stat_out}, {32'h1234_FFFF, 3'b100});
        // R4 double-word left by 32 clears, A1 gets bit 0
        run(4'd4, 32'h0000_0001, 1'b1, 8'd32, 8'd0, 3'b011);
        check("R4 full", {acc_out, stat_out}, {32'h0, 3'b100});
        // R4 count above width behaves as full width
        run(4'd5, 32'h8000_0000, 1'b1, 8'd200, 8'd0, 3'b000);
        check("R4 over", {acc_out, stat_out}, {32'h0, 3'b100});
        // R6 rotate by 32 keeps the value, A1 from bit 0
        run(4'd6, 32'h0000_0001, 1'b1, 8'd32, 8'd0, 3'b000);
        check("R6 full", {acc_out, stat_out}, {32'h0000_0001, 3'b100});
        run(4'd7, 32'h8000_0000, 1'b1, 8'd32, 8'd0, 3'b000);
        check("R6 full right", {acc_out, stat_out}, {32'h8000_0000, 3'b100});
        // R2 count taken from second accumulator, immediate ignored
        run(4'd4, 32'h0000_00F0, 1'b0, 8'd9, 8'd3, 3'b000);
        check("R2 acc count", {acc_out, stat_out}, {32'h0000_0780, 3'b000});
        run(4'd3, 32'hAAAA_0F00, 1'b1, 8'd4, 8'd0, 3'b000);
        check("R2 imm count", {acc_out, stat_out}, {32'hAAAA_00F0, 3'b000});
        // R8 zero count from second accumulator keeps flags
        run(4'd1, 32'h9188_2334, 1'b0, 8'd5, 8'd0, 3'b111);
        check("R8", {acc_out, stat_out}, {32'h9188_2334, 3'b111});
        // R7 rotate through A1 with A1 set
        run(4'd8, 32'h7FFF_FFF0, 1'b0, 8'd0, 8'd0, 3'b111);
        check("R7 left", {acc_out, stat_out}, {32'hFFFF_FFE1, 3'b000});
        run(4'd9, 32'h0FFF_FFFE, 1'b0, 8'd0, 8'd0, 3'b111);
        check("R7 right", {acc_out, stat_out}, {32'h87FF_FFFF, 3'b000});
        // R10 unknown op
        run(4'd12, 32'hDEAD_BEEF, 1'b1, 8'd3, 8'd0, 3'b101);
        check("R10", {acc_out, stat_out}, {32'hDEAD_BEEF, 3'b101});

        // R1 outputs hold while idle under changed inputs
        held = {acc_out, stat_out};
        @(negedge clk);
        op = 4'd4; acc_a = 32'h1; imm_cnt = 8'd1; use_imm = 1'b1; stat_in = 3'b010;
        @(negedge clk);
        check("R1 hold", {acc_out, stat_out}, held);
        check("R1 idle done", {34'h0, done}, 35'h0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] o;
            o = ($urandom % 16 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
            run(o, $urandom, 1'($urandom), pick_cnt(), pick_cnt(), 3'($urandom));
        end

        // Back-to-back requests
        @(negedge clk);
        op = 4'd6; acc_a = 32'h8000_0001; use_imm = 1'b1; imm_cnt = 8'd1; stat_in = 3'b000;
        in_valid = 1'b1;
        @(negedge clk);
        check("R6 b2b", {acc_out, stat_out}, {32'h0000_0003, 3'b100});
        op = 4'd2; acc_a = 32'h5555_4001; imm_cnt = 8'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 b2b", {acc_out, stat_out}, {32'h5555_0004, 3'b100});
        check("R1 b2b done", {34'h0, done}, 35'h1);

        // Reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {acc_out, stat_out, 2'b00} >> 2, 35'h0);
        rst_n = 1'b1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule